// File: doc/BRIEF.md
# Processor status trace output controller

This block drives the pins that an external debug probe watches to follow a processor core. Each cycle the core presents a 4-bit status code and a 4-bit data nibble. The block re-times them onto a status bus and a data bus. It also generates a sample clock whose rising edge sits in the middle of each valid window, and a flag that is high when every status bit is set. The sample clock stays low after reset until the core issues one of the start codes while it is processing the reset exception. A quiesce control freezes the sample clock and both buses for probes that do not need real-time trace. The breakpoint logic stays active while the pins are frozen.

A manual breakpoint input from the probe is synchronised and acted on once per assertion. With the disable bit clear, the request halts the core when the current instruction completes. The status bus then reads all ones until the core is resumed. With the disable bit set, the same request becomes a one-cycle debug interrupt request to the core.

Top module: `core_status_trace`

## Requirements
- R1: With the interrupt-mode bit low, a breakpoint request is held pending while `insn_done_i` is low. `halt_o` rises in the cycle after the first cycle in which a pending request meets `insn_done_i` high.
- R2: While `halt_o` is high, each status update drives `stat_o` to 4'hF instead of the core's code.
- R3: With the interrupt-mode bit high, a breakpoint request gives exactly one cycle of `dbg_irq_o`, and `halt_o` stays low even while `insn_done_i` is high.
- R4: `allst_o` is high exactly when all four bits of `stat_o` are 1.
- R5: `sclk_o` stays low from reset until a cycle in which `in_reset_exc_i` is high and `core_status_i` is 4'hC, 4'hD or 4'hF. No other code, and no code arriving while `in_reset_exc_i` is low, starts it. In the starting cycle the code is loaded onto `stat_o`.
- R6: While `quiesce_i` is high, `sclk_o`, `stat_o` and `ddat_o` hold their last values, and breakpoint requests are still acted on.
- R7: After `quiesce_i` falls, `sclk_o` toggles again and the buses resume updating.
- R8: Once started, `sclk_o` toggles every clock cycle. `stat_o` and `ddat_o` change only on the edge where `sclk_o` falls, and take the input values of the cycle before that edge. The rising edge of `sclk_o` therefore falls mid-window.
- R9: `brk_i` passes through a two-flop synchronizer and only its rising edge counts. A request takes effect on the third clock edge after `brk_i` goes high, and holding `brk_i` high gives a single request.
- R10: During and right after reset, `stat_o`, `ddat_o`, `sclk_o`, `allst_o`, `halt_o` and `dbg_irq_o` are all 0.
- R11: A cycle with `resume_i` high clears `halt_o` and any pending request on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| core_status_i | input | 4 | Status code from the core for the current cycle |
| core_data_i | input | 4 | Data nibble from the core for the current cycle |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| brk_i | input | 1 | Asynchronous manual breakpoint request |
| brk_irq_mode_i | input | 1 | 1: breakpoint raises a debug interrupt; 0: breakpoint halts |
| quiesce_i | input | 1 | Freeze the sample clock and trace buses |
| in_reset_exc_i | input | 1 | Core is processing its reset exception |
| resume_i | input | 1 | Leave the halted state |
| halt_o | output | 1 | Core halted by breakpoint |
| dbg_irq_o | output | 1 | One-cycle debug interrupt request |
| stat_o | output | 4 | Status bus to the probe |
| ddat_o | output | 4 | Data bus to the probe |
| sclk_o | output | 1 | Sample clock for the probe |
| allst_o | output | 1 | AND of all status bits |

## Verification
The assertions assume that every input except `brk_i` is synchronous to `clk`. They also assume that `resume_i` arrives only as a short pulse, and that `brk_irq_mode_i` does not change in the cycle a synchronised breakpoint edge is seen. The bench changes all inputs at the falling clock edge. It sets the interrupt-mode bit before it raises `brk_i` and leaves it fixed until the request has been handled. It drives `resume_i` for one cycle only.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int STAT_W = 4;
  localparam int DATA_W = 4;

  // Start codes: 4'hC, 4'hD, 4'hF (top two bits set, bit1 implies bit0)
  function automatic logic is_boot_code(input logic [STAT_W-1:0] c);
    return c[3] & c[2] & (~c[1] | c[0]);
  endfunction

  function automatic logic all_set(input logic [STAT_W-1:0] v);
    return &v;
  endfunction

  // Code shown on the status bus: all ones while halted
  function automatic logic [STAT_W-1:0] shown_code(input logic halted,
                                                    input logic [STAT_W-1:0] raw);
    return halted ? {STAT_W{1'b1}} : raw;
  endfunction
endpackage

// File: rtl/brk_edge_sync.sv
module brk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[LAST];
    end
  end

  assign rise_o = chain[LAST] & ~prev;
endmodule

// File: rtl/brk_arbiter.sv
module brk_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic irq_mode_i,
  input  logic insn_done_i,
  input  logic resume_i,
  output logic pend_o,
  output logic halted_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o   <= 1'b0;
      halted_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= rise_i & irq_mode_i;
      if (resume_i) begin
        halted_o <= 1'b0;
        pend_o   <= 1'b0;
      end else if (pend_o && insn_done_i) begin
        halted_o <= 1'b1;
        pend_o   <= 1'b0;
      end else if (rise_i && !irq_mode_i && !halted_o) begin
        pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_phase_gen.sv
module trace_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic quiesce_i,
  output logic running_o,
  output logic sclk_o,
  output logic upd_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_o <= 1'b0;
      sclk_o    <= 1'b0;
    end else begin
      if (start_i) running_o <= 1'b1;
      if (running_o && !quiesce_i) sclk_o <= ~sclk_o;
    end
  end

  // Buses load on the edge where the sample clock falls
  assign upd_o = running_o & ~quiesce_i & sclk_o;
endmodule

// File: rtl/trace_pin_reg.sv
module trace_pin_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/core_status_trace.sv
module core_status_trace
  import trace_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] core_status_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic              insn_done_i,
  input  logic              brk_i,
  input  logic              brk_irq_mode_i,
  input  logic              quiesce_i,
  input  logic              in_reset_exc_i,
  input  logic              resume_i,
  output logic              halt_o,
  output logic              dbg_irq_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [DATA_W-1:0] ddat_o,
  output logic              sclk_o,
  output logic              allst_o
);
  // Named internal events
  logic brk_rise;
  logic halt_pend;
  logic trace_run;
  logic trace_upd;
  logic boot_hit;
  logic pin_load;
  logic [STAT_W-1:0] stat_next;

  brk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(brk_i), .rise_o(brk_rise)
  );

  brk_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .rise_i(brk_rise), .irq_mode_i(brk_irq_mode_i),
    .insn_done_i(insn_done_i), .resume_i(resume_i),
    .pend_o(halt_pend), .halted_o(halt_o), .irq_o(dbg_irq_o)
  );

  assign boot_hit = ~trace_run & in_reset_exc_i & is_boot_code(core_status_i);

  trace_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .start_i(boot_hit), .quiesce_i(quiesce_i),
    .running_o(trace_run), .sclk_o(sclk_o), .upd_o(trace_upd)
  );

  assign pin_load  = boot_hit | trace_upd;
  assign stat_next = shown_code(halt_o, core_status_i);

  trace_pin_reg #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .load_i(pin_load), .d_i(stat_next), .q_o(stat_o)
  );

  trace_pin_reg #(.W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load_i(pin_load), .d_i(core_data_i), .q_o(ddat_o)
  );

  assign allst_o = all_set(stat_o);
endmodule

// File: rtl/core_status_trace_chk.sv
module core_status_trace_chk
  import trace_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done_i,
  input logic              resume_i,
  input logic              brk_irq_mode_i,
  input logic              quiesce_i,
  input logic [STAT_W-1:0] stat_o,
  input logic [DATA_W-1:0] ddat_o,
  input logic              sclk_o,
  input logic              allst_o,
  input logic              halt_o,
  input logic              dbg_irq_o,
  input logic              brk_rise,
  input logic              halt_pend,
  input logic              trace_run,
  input logic              trace_upd,
  input logic              boot_hit
);
  a_r1_halt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pend && insn_done_i && !resume_i |=> halt_o);

  a_r2_halt_shows_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    trace_upd && halt_o |=> stat_o == {STAT_W{1'b1}});

  a_r3_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    brk_rise && brk_irq_mode_i |=> dbg_irq_o);

  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq_o |=> !dbg_irq_o);

  a_r4_allst_and: assert property (@(posedge clk) disable iff (!rst_n)
    allst_o == (stat_o == {STAT_W{1'b1}}));

  a_r5_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_run |-> !sclk_o);

  a_r5_boot_starts: assert property (@(posedge clk) disable iff (!rst_n)
    boot_hit |=> trace_run);

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_i && trace_run |=> $stable(sclk_o) && $stable(stat_o) && $stable(ddat_o));

  a_r7_resume_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !quiesce_i && trace_run |=> !$stable(sclk_o));

  a_r8_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    trace_run && $past(trace_run) && !$stable(stat_o) |-> $fell(sclk_o));

  a_r9_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
    brk_rise |=> !brk_rise);

  a_r11_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    resume_i |=> !halt_o && !halt_pend);
endmodule

bind core_status_trace core_status_trace_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done_i), .resume_i(resume_i),
  .brk_irq_mode_i(brk_irq_mode_i), .quiesce_i(quiesce_i),
  .stat_o(stat_o), .ddat_o(ddat_o), .sclk_o(sclk_o), .allst_o(allst_o),
  .halt_o(halt_o), .dbg_irq_o(dbg_irq_o), .brk_rise(brk_rise),
  .halt_pend(halt_pend), .trace_run(trace_run), .trace_upd(trace_upd),
  .boot_hit(boot_hit)
);

// File: tb/core_status_trace_bench.sv
module core_status_trace_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] core_status_i = '0;
  logic [3:0] core_data_i = '0;
  logic       insn_done_i = 1'b0;
  logic       brk_i = 1'b0;
  logic       brk_irq_mode_i = 1'b0;
  logic       quiesce_i = 1'b0;
  logic       in_reset_exc_i = 1'b0;
  logic       resume_i = 1'b0;
  logic       halt_o, dbg_irq_o, sclk_o, allst_o;
  logic [3:0] stat_o, ddat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  core_status_trace u_core_status_trace (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic to_high_phase();
    @(negedge clk);
    while (sclk_o !== 1'b1) @(negedge clk);
  endtask

  task automatic t_reset();
    check(stat_o == 0 && ddat_o == 0, "R10 buses", {stat_o, ddat_o}, 0);
    check(sclk_o == 0 && allst_o == 0, "R10 clock/flag", {sclk_o, allst_o}, 0);
    check(halt_o == 0 && dbg_irq_o == 0, "R10 halt/irq", {halt_o, dbg_irq_o}, 0);
  endtask

  task automatic t_boot();
    int bad = 0;
    int tog = 0;
    logic last;
    in_reset_exc_i = 1; core_status_i = 4'h3;
    repeat (4) begin @(negedge clk); if (sclk_o) bad++; end
    in_reset_exc_i = 0; core_status_i = 4'hC;
    repeat (4) begin @(negedge clk); if (sclk_o) bad++; end
    in_reset_exc_i = 1; core_status_i = 4'hE;
    repeat (4) begin @(negedge clk); if (sclk_o) bad++; end
    check(bad == 0, "R5 clock held before start code", bad, 0);
    core_status_i = 4'hD; core_data_i = 4'h2;
    @(negedge clk);
    check(stat_o == 4'hD && sclk_o == 0, "R5 start code loaded", {stat_o, 3'b0, sclk_o}, 8'hD0);
    in_reset_exc_i = 0; core_status_i = 4'h0;
    @(negedge clk);
    check(sclk_o == 1, "R5 clock starts", sclk_o, 1);
    last = sclk_o;
    repeat (8) begin @(negedge clk); if (sclk_o != last) tog++; last = sclk_o; end
    check(tog == 8, "R8 toggles every cycle", tog, 8);
  endtask

  task automatic t_phase();
    to_high_phase();
    core_status_i = 4'hA; core_data_i = 4'h5;
    @(negedge clk);
    check(sclk_o == 0 && stat_o == 4'hA && ddat_o == 4'h5, "R8 load on falling edge",
          {sclk_o, stat_o, ddat_o}, {1'b0, 8'hA5});
    core_status_i = 4'h6; core_data_i = 4'h1;
    @(negedge clk);
    check(sclk_o == 1 && stat_o == 4'hA && ddat_o == 4'h5, "R8 hold on rising edge",
          {sclk_o, stat_o, ddat_o}, {1'b1, 8'hA5});
    @(negedge clk);
    check(stat_o == 4'h6 && ddat_o == 4'h1, "R8 next window", {stat_o, ddat_o}, 8'h61);
  endtask

  task automatic t_allst();
    to_high_phase();
    core_status_i = 4'hF;
    @(negedge clk);
    check(allst_o == 1, "R4 all ones", allst_o, 1);
    core_status_i = 4'h7;
    repeat (2) @(negedge clk);
    check(stat_o == 4'h7 && allst_o == 0, "R4 not all ones", {stat_o, allst_o}, 8'hE);
  endtask

  task automatic t_halt();
    brk_irq_mode_i = 0; insn_done_i = 0; core_status_i = 4'h2;
    @(negedge clk); brk_i = 1;
    repeat (10) @(negedge clk);
    check(halt_o == 0, "R1 waits for instruction end", halt_o, 0);
    insn_done_i = 1;
    @(negedge clk);
    check(halt_o == 1, "R1 halts after instruction end", halt_o, 1);
    insn_done_i = 0;
    repeat (4) @(negedge clk);
    check(stat_o == 4'hF && allst_o == 1, "R2 status reads F while halted", stat_o, 4'hF);
    resume_i = 1;
    @(negedge clk); resume_i = 0;
    check(halt_o == 0, "R11 resume clears halt", halt_o, 0);
    insn_done_i = 1;
    repeat (6) @(negedge clk);
    check(halt_o == 0, "R9 held level gives no second halt", halt_o, 0);
    insn_done_i = 0; brk_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_irq();
    int hi = 0;
    int first = 0;
    int hbad = 0;
    brk_irq_mode_i = 1; insn_done_i = 1;
    @(negedge clk); brk_i = 1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (dbg_irq_o) begin hi++; if (first == 0) first = i; end
      if (halt_o) hbad++;
    end
    check(hi == 1, "R3 single interrupt pulse", hi, 1);
    check(first == 3, "R9 request on third edge", first, 3);
    check(hbad == 0, "R3 no halt in interrupt mode", hbad, 0);
    brk_i = 0; insn_done_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_quiesce();
    logic s0;
    logic [3:0] st0, dd0;
    int hi = 0;
    int tog = 0;
    logic last;
    @(negedge clk);
    quiesce_i = 1; s0 = sclk_o; st0 = stat_o; dd0 = ddat_o;
    core_status_i = 4'h9; core_data_i = 4'hB; brk_irq_mode_i = 1; brk_i = 1;
    repeat (8) begin @(negedge clk); if (dbg_irq_o) hi++; end
    check(sclk_o == s0, "R6 clock frozen", sclk_o, s0);
    check(stat_o == st0 && ddat_o == dd0, "R6 buses frozen", {stat_o, ddat_o}, {st0, dd0});
    check(hi == 1, "R6 breakpoint active while frozen", hi, 1);
    brk_i = 0; quiesce_i = 0;
    last = sclk_o;
    repeat (6) begin @(negedge clk); if (sclk_o != last) tog++; last = sclk_o; end
    check(tog == 6, "R7 clock resumes", tog, 6);
    check(stat_o == 4'h9 && ddat_o == 4'hB, "R7 buses resume", {stat_o, ddat_o}, 8'h9B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_boot();
    t_phase();
    t_allst();
    t_halt();
    t_irq();
    t_quiesce();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule